// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline, where register operands are read in the second stage and results are written back in the fifth. It checks whether the instruction now in decode reads a register that a load, currently one stage ahead in execute, is about to write. The loaded value is not available until the end of the memory stage. An instruction that needs that value as an arithmetic operand in the very next cycle therefore cannot be served by forwarding. The block then holds the program counter and the fetch/decode latch and sends an empty instruction into the decode/execute latch. After one such cycle the dependent instruction receives the value through forwarding from the memory/write-back latch.

The unit is purely combinational. The stall is raised in the same cycle that the hazard is visible in decode. A store whose only use of the loaded register is the data it writes to memory is not stalled, because memory-stage forwarding delivers that value in time. A store that uses the loaded register to form its address is stalled. A load that targets register 0 never causes a stall. An instruction two or more slots behind the load is never stalled, since by then the load has left execute. Choosing the forwarding paths is handled elsewhere.

The decode-stage control enables pass through the unit to the decode/execute latch. During a stall the unit forces them to zero, so the bubble writes no register and no memory and performs no load.

Top module: `load_use_stall`

## Requirements
- R1: When `ex_mem_read_i` is 0, `pc_we_o` and `ifid_we_o` are 1 and `idex_bubble_o` is 0, whatever the decode-stage inputs are.
- R2: When `ex_mem_read_i` is 1, `ex_rd_i` is nonzero, `id_rs1_used_i` is 1 and `id_rs1_i` equals `ex_rd_i`, the unit stalls: `pc_we_o`=0, `ifid_we_o`=0, `idex_bubble_o`=1.
- R3: When `ex_mem_read_i` is 1, `ex_rd_i` is nonzero, `id_rs2_used_i` is 1, `id_store_i` is 0 and `id_rs2_i` equals `ex_rd_i`, the unit stalls.
- R4: When `ex_rd_i` is 0, no stall is raised, even if a used source field is also 0 and `ex_mem_read_i` is 1.
- R5: A source field whose used flag is 0 never causes a stall, even if it equals `ex_rd_i`.
- R6: When `id_store_i` is 1, a match on `id_rs2_i` (the store data) does not stall. A match on `id_rs1_i` (the store base address) does stall.
- R7: While `idex_bubble_o` is 1, `idex_reg_we_o`, `idex_mem_we_o` and `idex_mem_re_o` are 0. Otherwise they equal `id_reg_we_i`, `id_mem_we_i` and `id_mem_re_i`.
- R8: The outputs follow the inputs within the same cycle, with no clock edge between a change of input and the resulting stall or release.
- R9: `pc_we_o` and `ifid_we_o` are always equal, and each is the inverse of `idex_bubble_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | Decode first source register (ALU operand or store base) |
| id_rs1_used_i | input | 1 | Decode instruction reads the first source |
| id_rs2_i | input | REG_AW | Decode second source register (ALU operand or store data) |
| id_rs2_used_i | input | 1 | Decode instruction reads the second source |
| id_store_i | input | 1 | Decode instruction is a store; second source is store data |
| id_reg_we_i | input | 1 | Decode register-write enable |
| id_mem_we_i | input | 1 | Decode memory-write enable |
| id_mem_re_i | input | 1 | Decode memory-read enable |
| ex_mem_read_i | input | 1 | Execute-stage instruction is a load |
| ex_rd_i | input | REG_AW | Execute-stage destination register |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode latch write enable |
| idex_bubble_o | output | 1 | Insert an empty instruction into decode/execute |
| idex_reg_we_o | output | 1 | Register-write enable toward decode/execute |
| idex_mem_we_o | output | 1 | Memory-write enable toward decode/execute |
| idex_mem_re_o | output | 1 | Memory-read enable toward decode/execute |

## Verification
The assertions check continuously that the two hold enables match each other and oppose the bubble flag. They also check that a load into register 0 or a non-load in execute never stalls, that a live match on a used first source always stalls, and that the control enables are cleared exactly during a bubble. Whether a store-data match is spared while a base-address match or an ALU second-operand match is caught depends on combinations of decode and execute fields, so the bench's directed scenarios show it. The same holds for a disabled source flag masking a match, and for the outputs responding without a clock edge.

// File: rtl/load_use_pkg.sv
package load_use_pkg;
  typedef enum logic {
    ROLE_ALU        = 1'b0,
    ROLE_STORE_DATA = 1'b1
  } src_role_e;

  typedef struct packed {
    logic reg_we;
    logic mem_we;
    logic mem_re;
  } ex_ctrl_t;

  localparam ex_ctrl_t CTRL_NOP = '{reg_we: 1'b0, mem_we: 1'b0, mem_re: 1'b0};
endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
  parameter int REG_AW = 5
) (
  input  logic                    load_live_i,
  input  logic [REG_AW-1:0]       ex_rd_i,
  input  logic [REG_AW-1:0]       src_i,
  input  logic                    used_i,
  input  load_use_pkg::src_role_e role_i,
  output logic                    hit_o
);
  import load_use_pkg::*;
  // store data is forwarded in the memory stage, so it never needs a bubble
  always_comb hit_o = load_live_i && used_i && (role_i == ROLE_ALU) && (src_i == ex_rd_i);
endmodule

// File: rtl/lu_bubble_mux.sv
module lu_bubble_mux (
  input  logic                   bubble_i,
  input  load_use_pkg::ex_ctrl_t ctrl_i,
  output load_use_pkg::ex_ctrl_t ctrl_o
);
  import load_use_pkg::*;
  always_comb ctrl_o = bubble_i ? CTRL_NOP : ctrl_i;
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic              id_rs1_used_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs2_used_i,
  input  logic              id_store_i,
  input  logic              id_reg_we_i,
  input  logic              id_mem_we_i,
  input  logic              id_mem_re_i,
  input  logic              ex_mem_read_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              idex_bubble_o,
  output logic              idex_reg_we_o,
  output logic              idex_mem_we_o,
  output logic              idex_mem_re_o
);
  import load_use_pkg::*;

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] src_addr;
  logic [NUM_SRC-1:0]             src_used;
  src_role_e                      src_role [NUM_SRC];
  logic [NUM_SRC-1:0]             src_hit;
  logic                           load_live;
  logic                           stall;
  ex_ctrl_t                       ctrl_in, ctrl_out;

  // register 0 is hardwired, a load into it produces nothing to wait for
  assign load_live = ex_mem_read_i && (ex_rd_i != '0);

  assign src_addr[0] = id_rs1_i;
  assign src_addr[1] = id_rs2_i;
  assign src_used[0] = id_rs1_used_i;
  assign src_used[1] = id_rs2_used_i;
  assign src_role[0] = ROLE_ALU;
  assign src_role[1] = id_store_i ? ROLE_STORE_DATA : ROLE_ALU;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lu_src_cmp #(.REG_AW(REG_AW)) u_cmp (
      .load_live_i (load_live),
      .ex_rd_i     (ex_rd_i),
      .src_i       (src_addr[g]),
      .used_i      (src_used[g]),
      .role_i      (src_role[g]),
      .hit_o       (src_hit[g])
    );
  end

  assign stall = |src_hit;

  assign pc_we_o       = ~stall;
  assign ifid_we_o     = ~stall;
  assign idex_bubble_o = stall;

  assign ctrl_in = '{reg_we: id_reg_we_i, mem_we: id_mem_we_i, mem_re: id_mem_re_i};

  lu_bubble_mux u_mux (
    .bubble_i (stall),
    .ctrl_i   (ctrl_in),
    .ctrl_o   (ctrl_out)
  );

  assign idex_reg_we_o = ctrl_out.reg_we;
  assign idex_mem_we_o = ctrl_out.mem_we;
  assign idex_mem_re_o = ctrl_out.mem_re;
endmodule

// File: rtl/load_use_stall_chk.sv
module load_use_stall_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1_i,
  input logic              id_rs1_used_i,
  input logic              id_reg_we_i,
  input logic              id_mem_we_i,
  input logic              id_mem_re_i,
  input logic              ex_mem_read_i,
  input logic [REG_AW-1:0] ex_rd_i,
  input logic              pc_we_o,
  input logic              ifid_we_o,
  input logic              idex_bubble_o,
  input logic              idex_reg_we_o,
  input logic              idex_mem_we_o,
  input logic              idex_mem_re_o
);
  always_comb begin
    p_hold_pair_r9: assert (pc_we_o == ifid_we_o && idex_bubble_o == !pc_we_o)
      else $error("hold enables disagree with bubble");
    p_no_load_r1: assert (ex_mem_read_i || !idex_bubble_o)
      else $error("stall without load in execute");
    p_zero_dest_r4: assert (ex_rd_i != '0 || !idex_bubble_o)
      else $error("stall on load to register 0");
    p_rs1_hit_r2: assert (!(ex_mem_read_i && ex_rd_i != '0 && id_rs1_used_i
                            && id_rs1_i == ex_rd_i) || idex_bubble_o)
      else $error("first-source load-use missed");
    p_bubble_clears_r7: assert (!idex_bubble_o || !(idex_reg_we_o || idex_mem_we_o || idex_mem_re_o))
      else $error("bubble carries live enables");
    p_pass_r7: assert (idex_bubble_o || (idex_reg_we_o == id_reg_we_i
                       && idex_mem_we_o == id_mem_we_i && idex_mem_re_o == id_mem_re_i))
      else $error("enables altered without bubble");
  end
endmodule

bind load_use_stall load_use_stall_chk #(.REG_AW(REG_AW)) u_chk (
  .id_rs1_i      (id_rs1_i),
  .id_rs1_used_i (id_rs1_used_i),
  .id_reg_we_i   (id_reg_we_i),
  .id_mem_we_i   (id_mem_we_i),
  .id_mem_re_i   (id_mem_re_i),
  .ex_mem_read_i (ex_mem_read_i),
  .ex_rd_i       (ex_rd_i),
  .pc_we_o       (pc_we_o),
  .ifid_we_o     (ifid_we_o),
  .idex_bubble_o (idex_bubble_o),
  .idex_reg_we_o (idex_reg_we_o),
  .idex_mem_we_o (idex_mem_we_o),
  .idex_mem_re_o (idex_mem_re_o)
);

// File: tb/load_use_stall_test.sv
`timescale 1ns/1ps
module load_use_stall_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rd;
  logic id_rs1_used, id_rs2_used, id_store, id_reg_we, id_mem_we, id_mem_re, ex_mem_read;
  logic pc_we, ifid_we, idex_bubble, idex_reg_we, idex_mem_we, idex_mem_re;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  load_use_stall #(.REG_AW(AW)) uut (
    .id_rs1_i(id_rs1), .id_rs1_used_i(id_rs1_used),
    .id_rs2_i(id_rs2), .id_rs2_used_i(id_rs2_used),
    .id_store_i(id_store), .id_reg_we_i(id_reg_we),
    .id_mem_we_i(id_mem_we), .id_mem_re_i(id_mem_re),
    .ex_mem_read_i(ex_mem_read), .ex_rd_i(ex_rd),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_bubble_o(idex_bubble),
    .idex_reg_we_o(idex_reg_we), .idex_mem_we_o(idex_mem_we), .idex_mem_re_o(idex_mem_re)
  );

  task automatic cmp(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // order: pc_we, ifid_we, bubble, reg_we, mem_we, mem_re
  function automatic logic [5:0] outs();
    return {pc_we, ifid_we, idex_bubble, idex_reg_we, idex_mem_we, idex_mem_re};
  endfunction

  function automatic logic [5:0] stall_vec(input logic s);
    return s ? 6'b001000 : {2'b11, 1'b0, id_reg_we, id_mem_we, id_mem_re};
  endfunction

  task automatic drive(input logic [AW-1:0] r1, input logic u1, input logic [AW-1:0] r2,
                       input logic u2, input logic st, input logic ld, input logic [AW-1:0] rd);
    @(negedge clk);
    id_rs1 = r1; id_rs1_used = u1; id_rs2 = r2; id_rs2_used = u2;
    id_store = st; ex_mem_read = ld; ex_rd = rd;
    id_reg_we = ~st; id_mem_we = st; id_mem_re = 1'b0;
    #1;
  endtask

  task automatic t_idle_r1();
    id_reg_we = 1'b0; id_mem_we = 1'b0; id_mem_re = 1'b0;
    drive(5'd0, 0, 5'd0, 0, 0, 0, 5'd0);
    cmp("R1 idle", outs(), stall_vec(0));
    drive(5'd7, 1, 5'd7, 1, 0, 0, 5'd7);
    cmp("R1 non-load same rd", outs(), stall_vec(0));
  endtask

  task automatic t_alu_use_r2_r3();
    drive(5'd3, 1, 5'd9, 1, 0, 1, 5'd3);
    cmp("R2 rs1 load-use", outs(), stall_vec(1));
    drive(5'd4, 1, 5'd12, 1, 0, 1, 5'd12);
    cmp("R3 rs2 load-use", outs(), stall_vec(1));
    drive(5'd31, 1, 5'd31, 1, 0, 1, 5'd31);
    cmp("R2 both match r31", outs(), stall_vec(1));
    drive(5'd4, 1, 5'd5, 1, 0, 1, 5'd6);
    cmp("R2 no match", outs(), stall_vec(0));
  endtask

  task automatic t_zero_r4();
    drive(5'd0, 1, 5'd0, 1, 0, 1, 5'd0);
    cmp("R4 load to r0", outs(), stall_vec(0));
  endtask

  task automatic t_unused_r5();
    drive(5'd8, 0, 5'd8, 0, 0, 1, 5'd8);
    cmp("R5 unused sources", outs(), stall_vec(0));
    drive(5'd8, 0, 5'd2, 1, 0, 1, 5'd8);
    cmp("R5 rs1 flag off", outs(), stall_vec(0));
  endtask

  task automatic t_store_r6();
    drive(5'd1, 1, 5'd10, 1, 1, 1, 5'd10);
    cmp("R6 store data only", outs(), stall_vec(0));
    drive(5'd10, 1, 5'd2, 1, 1, 1, 5'd10);
    cmp("R6 store base", outs(), stall_vec(1));
  endtask

  task automatic t_ctrl_r7();
    drive(5'd6, 1, 5'd0, 0, 0, 1, 5'd6);
    id_reg_we = 1; id_mem_we = 1; id_mem_re = 1; #1;
    cmp("R7 bubble clears enables", outs(), 6'b001000);
    drive(5'd6, 1, 5'd0, 0, 0, 1, 5'd7);
    id_reg_we = 1; id_mem_we = 0; id_mem_re = 1; #1;
    cmp("R7 pass enables", outs(), 6'b110101);
  endtask

  task automatic t_comb_r8_r9();
    drive(5'd11, 1, 5'd0, 0, 0, 0, 5'd11);
    cmp("R8 before load flag", outs(), stall_vec(0));
    #1 ex_mem_read = 1'b1; #1;
    cmp("R8 same-cycle stall", outs(), stall_vec(1));
    cmp("R9 enable pair", {4'b0, pc_we, ifid_we}, {4'b0, ~idex_bubble, ~idex_bubble});
    #1 ex_rd = 5'd12; #1;
    cmp("R8 same-cycle release", outs(), stall_vec(0));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_idle_r1();
    t_alu_use_r2_r3();
    t_zero_r4();
    t_unused_r5();
    t_store_r6();
    t_ctrl_r7();
    t_comb_r8_r9();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule